// File: doc/BRIEF.md
# Memory-Immediate Add Sequencer

This block is a multi-cycle controller that carries out a single "add a constant byte to a byte in memory" instruction. It owns the instruction pointer and drives one synchronous, byte-wide memory port. Once started, it fetches the opcode and decodes the addressing mode. It fetches an address byte when the mode needs one, then fetches the constant. After that it reads the memory operand, writes the 8-bit sum back to the same address and updates four condition flags.

The instruction pointer moves forward one byte at a time, after each byte of the instruction is fetched. When the instruction ends, the pointer addresses the next instruction. A mode that takes its address straight from the base register fetches no address byte, so the two cycles for that byte are skipped. A one-cycle `done` pulse marks the end of the instruction. The sequencer is then idle and waits for the next `start`.

Top module: `memimm_add_seq`

## Requirements
- R1: While reset is held and on its release: `ip` is 0, all four flags are 0, `done` is 0, and neither `mem_rd` nor `mem_wr` is asserted.
- R2: When `start` is sampled in idle, the next cycle reads memory at the current `ip`. `ip` rises by exactly one after each fetched instruction byte: the opcode, the address byte and the constant. It never rises by more than one in a cycle, and it ends the instruction at the byte that follows it.
- R3: Decode uses opcode bits [1:0]. Bit 0 = 1 selects base register plus the fetched byte (zero-extended, modulo 2^AW). Bits = 00 select the fetched byte as an absolute address. Bits = 10 select the base register alone and fetch no address byte.
- R4: Read data is taken one cycle after `mem_rd`. `done` is high 12 cycles after the edge that samples `start` when an address byte is fetched, and 10 cycles after it when no address byte is fetched.
- R5: The constant is read at `ip` after the address step. The operand is then read at the effective address. One cycle later, a single-cycle write stores (operand + constant) mod 256 at that same address.
- R6: The flags are computed from the 8-bit sum. Zero means the sum is 0. Carry means the addition carried out of bit 7. Sign is bit 7 of the sum. Overflow means both inputs had the same bit 7 and the sum's bit 7 differs from it. The flags change only on the edge that raises `done`.
- R7: `done` is high for exactly one cycle, and the sequencer is idle in that cycle.
- R8: `start` asserted while an instruction is in progress is ignored: the access sequence, `ip` and the result are unchanged.
- R9: `mem_rd` and `mem_wr` are never asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin one instruction when idle |
| base_reg | input | AW | Base register value, held stable during an instruction |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd` |
| mem_addr | output | AW | Memory address for a read or write |
| mem_rd | output | 1 | Read request |
| mem_wr | output | 1 | Write request |
| mem_wdata | output | 8 | Write data (the sum) |
| ip | output | AW | Instruction pointer |
| done | output | 1 | One-cycle end-of-instruction pulse |
| flag_zero | output | 1 | Sum was zero |
| flag_carry | output | 1 | Carry out of bit 7 |
| flag_sign | output | 1 | Bit 7 of the sum |
| flag_ovf | output | 1 | Signed overflow |

## Verification
The reference model turns each instruction into a per-cycle list of expected port values. The list starts with the cycle after `start` is sampled: the opcode read at `ip`, then every wait and decode cycle and every read and write. It ends with `done` in cycle 12, or in cycle 10 for the base-only mode. Each entry is compared at the falling edge of its own cycle, so every register on the path has settled. Flags are compared in the `done` cycle. The written byte is compared in the bench memory one cycle later.

// File: rtl/mia_pkg.sv
// Package: shared types for the memory-immediate add sequencer.
// Assumes byte-wide data; the state encoding is internal to the block.
package mia_pkg;

    localparam int unsigned BYTE_W = 8;

    // Sequencer states, in execution order.
    typedef enum logic [3:0] {
        S_IDLE,
        S_FOPC,   // issue opcode read
        S_WOPC,   // capture opcode
        S_DEC,    // choose address path
        S_FADR,   // issue address-byte read
        S_WADR,   // capture address byte, form effective address
        S_FIMM,   // issue constant read
        S_WIMM,   // capture constant
        S_FOPR,   // issue operand read
        S_WOPR,   // capture operand
        S_WRITE,  // write sum back
        S_FLAGS   // latch flags
    } seq_state_e;

    // Condition flags computed from the 8-bit sum.
    typedef struct packed {
        logic zero;
        logic carry;
        logic sign;
        logic ovf;
    } flags_t;

endpackage

// File: rtl/mia_ip_ctr.sv
// Module: instruction pointer register.
// Adds one on each instruction-byte fetch and clears on reset.
// Assumes the controller asks for at most one step per cycle.
module mia_ip_ctr #(
    parameter int unsigned AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    output logic [AW-1:0] ip
);

    // Pointer update: clear on reset, add one on step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ip <= '0;
        else if (step)
            ip <= ip + AW'(1);
    end

    // R2: the pointer moves by zero or one in any cycle.
    a_r2_ip_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (ip == $past(ip)) || (ip == $past(ip) + AW'(1)));

endmodule

// File: rtl/mia_alu.sv
// Module: byte adder with condition flags.
// Purely combinational; the caller holds the inputs stable.
module mia_alu
    import mia_pkg::*;
(
    input  logic [BYTE_W-1:0] opa,
    input  logic [BYTE_W-1:0] opb,
    output logic [BYTE_W-1:0] sum,
    output flags_t            flags
);

    logic [BYTE_W:0] wide;

    // Sum and flags from the two operands.
    always_comb begin
        wide        = {1'b0, opa} + {1'b0, opb};
        sum         = wide[BYTE_W-1:0];
        flags.zero  = (wide[BYTE_W-1:0] == '0);
        flags.carry = wide[BYTE_W];
        flags.sign  = wide[BYTE_W-1];
        flags.ovf   = (opa[BYTE_W-1] == opb[BYTE_W-1]) &&
                      (wide[BYTE_W-1] != opa[BYTE_W-1]);
    end

endmodule

// File: rtl/mia_fsm.sv
// Module: step controller for the add-constant-to-memory instruction.
// Each read state is followed by a wait state (one-cycle read latency).
// Assumes mode bits are valid from the S_DEC cycle onward.
module mia_fsm
    import mia_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [1:0] mode,
    output seq_state_e state
);

    seq_state_e nxt;
    logic       need_adr;

    // Address byte needed unless the mode is base-only (10).
    assign need_adr = mode[0] | ~mode[1];

    // Next-state selection.
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (start) nxt = S_FOPC;
            S_FOPC:  nxt = S_WOPC;
            S_WOPC:  nxt = S_DEC;
            S_DEC:   nxt = need_adr ? S_FADR : S_FIMM;
            S_FADR:  nxt = S_WADR;
            S_WADR:  nxt = S_FIMM;
            S_FIMM:  nxt = S_WIMM;
            S_WIMM:  nxt = S_FOPR;
            S_FOPR:  nxt = S_WOPR;
            S_WOPR:  nxt = S_WRITE;
            S_WRITE: nxt = S_FLAGS;
            S_FLAGS: nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= S_IDLE;
        else
            state <= nxt;
    end

    // R3: base-only mode skips the address-byte steps.
    a_r3_skip_adr: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DEC && mode == 2'b10) |=> state == S_FIMM);

    // R3: other modes take the address-byte steps.
    a_r3_take_adr: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DEC && mode != 2'b10) |=> state == S_FADR);

    // R8: start outside idle does not restart the sequence.
    a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WOPC && start) |=> state == S_DEC);

endmodule

// File: rtl/memimm_add_seq.sv
// Module: memory-immediate add sequencer (top).
// Runs one add-constant-to-memory instruction on a synchronous byte memory.
// Assumes read data arrives the cycle after mem_rd and base_reg is stable
// while an instruction runs.
module memimm_add_seq
    import mia_pkg::*;
#(
    parameter int unsigned AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [AW-1:0]     base_reg,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic [AW-1:0]     mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic [AW-1:0]     ip,
    output logic              done,
    output logic              flag_zero,
    output logic              flag_carry,
    output logic              flag_sign,
    output logic              flag_ovf
);

    seq_state_e        state;
    logic [1:0]        mode_q;
    logic [AW-1:0]     ea_q;
    logic [BYTE_W-1:0] imm_q;
    logic [BYTE_W-1:0] opr_q;
    logic [BYTE_W-1:0] sum;
    flags_t            alu_flags;
    flags_t            flags_q;
    logic              done_q;
    logic              ip_step;
    logic              fetch_at_ip;

    mia_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .mode  (mode_q),
        .state (state)
    );

    mia_ip_ctr #(.AW(AW)) u_ip (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (ip_step),
        .ip    (ip)
    );

    mia_alu u_alu (
        .opa   (opr_q),
        .opb   (imm_q),
        .sum   (sum),
        .flags (alu_flags)
    );

    // Instruction-byte fetches read at ip and advance it.
    assign fetch_at_ip = (state == S_FOPC) || (state == S_FADR) ||
                         (state == S_FIMM);
    assign ip_step     = fetch_at_ip;

    // Memory port drive.
    always_comb begin
        mem_rd    = fetch_at_ip || (state == S_FOPR);
        mem_wr    = (state == S_WRITE);
        mem_wdata = sum;
        if (fetch_at_ip)
            mem_addr = ip;
        else if (state == S_FOPR || state == S_WRITE)
            mem_addr = ea_q;
        else
            mem_addr = '0;
    end

    // Datapath capture of opcode mode, address, constant and operand.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            ea_q   <= '0;
            imm_q  <= '0;
            opr_q  <= '0;
        end else begin
            unique case (state)
                S_WOPC: mode_q <= mem_rdata[1:0];
                S_DEC:  if (mode_q == 2'b10) ea_q <= base_reg;
                S_WADR: ea_q <= mode_q[0] ? (base_reg + AW'(mem_rdata))
                                          : AW'(mem_rdata);
                S_WIMM: imm_q <= mem_rdata;
                S_WOPR: opr_q <= mem_rdata;
                default: ;
            endcase
        end
    end

    // Flags and done: latched at the end of the flags step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= (state == S_FLAGS);
            if (state == S_FLAGS)
                flags_q <= alu_flags;
        end
    end

    assign done       = done_q;
    assign flag_zero  = flags_q.zero;
    assign flag_carry = flags_q.carry;
    assign flag_sign  = flags_q.sign;
    assign flag_ovf   = flags_q.ovf;

    // R9: no read and write together.
    a_r9_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R7: done lasts one cycle.
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5: write is followed by done two cycles later.
    a_r5_write_then_done: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> ##1 done);

    // R6: flags only change as done rises.
    a_r6_flags_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$stable({flag_zero, flag_carry, flag_sign, flag_ovf})
        |-> $rose(done));

    // R2: start in idle leads to an opcode read at the pointer.
    a_r2_start_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && start) |=> (mem_rd && mem_addr == ip));

endmodule

// File: tb/tb_memimm_add_seq.sv
`timescale 1ns/1ps
module tb_memimm_add_seq;

    localparam int AW = 8;

    typedef struct {
        bit       rd;
        bit       wr;
        bit [7:0] addr;
        bit [7:0] wdata;
        bit [7:0] ip;
        bit       done;
    } exp_t;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst_n;
    logic          start;
    logic [AW-1:0] base_reg;
    logic [7:0]    mem_rdata;
    logic [AW-1:0] mem_addr;
    logic          mem_rd, mem_wr;
    logic [7:0]    mem_wdata;
    logic [AW-1:0] ip;
    logic          done, flag_zero, flag_carry, flag_sign, flag_ovf;

    logic [7:0] mem [256];
    logic       ld_en;
    logic [7:0] ld_addr, ld_data;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit [7:0] ipm = 0;
    exp_t q[$];

    memimm_add_seq #(.AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .base_reg(base_reg),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .ip(ip), .done(done),
        .flag_zero(flag_zero), .flag_carry(flag_carry),
        .flag_sign(flag_sign), .flag_ovf(flag_ovf)
    );

    // Synchronous memory model: one-cycle read latency.
    always @(posedge clk) begin
        if (ld_en) mem[ld_addr] <= ld_data;
        else if (mem_wr) mem[mem_addr] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr];
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            fails  = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run hung, actual cycles %0d expected < 20000", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic check(input string req, input bit ok, input string act, input string exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %s expected %s", req, act, exp);
        end
    endtask

    task automatic poke(input bit [7:0] a, input bit [7:0] d);
        @(negedge clk);
        ld_en = 1'b1; ld_addr = a; ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    function automatic exp_t mk(bit rd, bit wr, bit [7:0] a, bit [7:0] wd, bit [7:0] p, bit d);
        exp_t e;
        e.rd = rd; e.wr = wr; e.addr = a; e.wdata = wd; e.ip = p; e.done = d;
        return e;
    endfunction

    // Reference model: one instruction at ipm, compared every cycle (R2-R8).
    task automatic run_instr(input bit [7:0] base, input int extra_start_at);
        bit [7:0] op, cur, ea, imm, opr, sum;
        bit [8:0] wide;
        bit       need;
        bit       ez, ec, es, ev;
        q.delete();
        op  = mem[ipm];
        q.push_back(mk(1, 0, ipm, 0, ipm, 0));
        cur = ipm + 8'd1;
        q.push_back(mk(0, 0, 0, 0, cur, 0));
        q.push_back(mk(0, 0, 0, 0, cur, 0));
        need = op[0] | ~op[1];
        if (need) begin
            q.push_back(mk(1, 0, cur, 0, cur, 0));
            ea  = op[0] ? base + mem[cur] : mem[cur];
            cur = cur + 8'd1;
            q.push_back(mk(0, 0, 0, 0, cur, 0));
        end else begin
            ea = base;
        end
        imm = mem[cur];
        q.push_back(mk(1, 0, cur, 0, cur, 0));
        cur = cur + 8'd1;
        q.push_back(mk(0, 0, 0, 0, cur, 0));
        opr  = mem[ea];
        wide = {1'b0, opr} + {1'b0, imm};
        sum  = wide[7:0];
        q.push_back(mk(1, 0, ea, 0, cur, 0));
        q.push_back(mk(0, 0, 0, 0, cur, 0));
        q.push_back(mk(0, 1, ea, sum, cur, 0));
        q.push_back(mk(0, 0, 0, 0, cur, 0));
        q.push_back(mk(0, 0, 0, 0, cur, 1));
        ez = (sum == 0); ec = wide[8]; es = sum[7];
        ev = (opr[7] == imm[7]) && (sum[7] != opr[7]);

        @(negedge clk);
        base_reg = base;
        start    = 1'b1;
        for (int i = 0; i < q.size(); i++) begin
            @(negedge clk);
            start = (i == extra_start_at);
            begin
                exp_t e;
                bit ok;
                e  = q[i];
                ok = (mem_rd == e.rd) && (mem_wr == e.wr) && (ip == e.ip) &&
                     (done == e.done) &&
                     (!(e.rd || e.wr) || mem_addr == e.addr) &&
                     (!e.wr || mem_wdata == e.wdata);
                check(e.wr ? "R5" : (e.done ? "R4" : (extra_start_at >= 0 ? "R8" : "R2")), ok,
                      $sformatf("cyc%0d rd=%0d wr=%0d addr=%h wd=%h ip=%h done=%0d",
                                i + 1, mem_rd, mem_wr, mem_addr, mem_wdata, ip, done),
                      $sformatf("rd=%0d wr=%0d addr=%h wd=%h ip=%h done=%0d",
                                e.rd, e.wr, e.addr, e.wdata, e.ip, e.done));
            end
        end
        start = 1'b0;
        check("R6", {flag_zero, flag_carry, flag_sign, flag_ovf} == {ez, ec, es, ev},
              $sformatf("%b", {flag_zero, flag_carry, flag_sign, flag_ovf}),
              $sformatf("%b", {ez, ec, es, ev}));
        check("R3", need ? (q.size() == 12) : (q.size() == 10),
              $sformatf("%0d", q.size()), need ? "12" : "10");
        @(negedge clk);
        check("R7", done == 1'b0, $sformatf("%0d", done), "0");
        check("R5", mem[ea] == sum, $sformatf("%h", mem[ea]), $sformatf("%h", sum));
        ipm = cur;
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; base_reg = '0; ld_en = 1'b0;
        ld_addr = '0; ld_data = '0;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state.
        check("R1", ip == 0 && !done && !mem_rd && !mem_wr &&
              {flag_zero, flag_carry, flag_sign, flag_ovf} == 4'b0,
              $sformatf("ip=%h done=%0d rd=%0d wr=%0d", ip, done, mem_rd, mem_wr),
              "ip=00 done=0 rd=0 wr=0 flags=0");
        rst_n = 1'b1;
        // Program: absolute, base+disp, base-only, base+disp wrapping.
        poke(8'h00, 8'h00); poke(8'h01, 8'h80); poke(8'h02, 8'h05);
        poke(8'h03, 8'h01); poke(8'h04, 8'h10); poke(8'h05, 8'hEB);
        poke(8'h06, 8'h02); poke(8'h07, 8'h7F);
        poke(8'h08, 8'h03); poke(8'h09, 8'h20); poke(8'h0A, 8'h80);
        poke(8'h80, 8'h10); poke(8'h90, 8'h01); poke(8'h10, 8'h80);
        @(negedge clk);
        check("R1", ip == 0 && !mem_rd && !mem_wr && !done,
              $sformatf("ip=%h rd=%0d wr=%0d", ip, mem_rd, mem_wr), "ip=00 idle");
        run_instr(8'h00, -1);   // R3 absolute: 0x10+0x05 at 0x80
        run_instr(8'h70, 4);    // R3 base+disp, R8 start mid-run: 0x15+0xEB
        run_instr(8'h90, -1);   // R3 base-only: 0x01+0x7F, sign+overflow
        run_instr(8'hF0, -1);   // R3 wrap 0xF0+0x20: 0x80+0x80, zero/carry/ovf
        repeat (3) @(negedge clk);
        check("R7", !done && !mem_rd && !mem_wr && ip == 8'h0B,
              $sformatf("done=%0d ip=%h", done, ip), "idle ip=0b");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule